// File: doc/BRIEF.md
# Two-channel down-counting event timer

A memory-mapped timer with several independent 64-bit down-counters behind a plain 32-bit register bus: one write strobe, an address, write data and a combinational read-data return. Each channel holds a 64-bit interval, which a control write with the reload bit set copies into the live counter. While enabled, the channel decrements on every prescaled tick. A tick that finds the counter at zero is an expiry. In periodic mode the channel then reloads and keeps running. In one-shot mode it stops and holds zero. Every expiry raises a sticky status bit. The interrupt output is the OR of those bits, each masked by its enable bit.

Disabling a channel does not stop it at once. The stop request models a crossing into a slower timer clock, so the channel goes on counting for a fixed number of further cycles before it halts. Driver code sets an all-ones interval, enables the channel, and reads the inverted low counter word as a rising time base. For a short event it shortens the requested interval by the stop margin.

Top module: `evt_timer_top`

## Requirements
- R1: After reset the interrupt-enable, status, control, interval and counter registers all read zero and `irq` is low.
- R2: The interval is written and read as a low word at channel base + 0x4 and a high word at base + 0x8. The control register at the base reads enable in bit 0, prescaler select in bits 6:4 and one-shot in bit 7. Bit 1 always reads 0.
- R3: A control write with bit 1 set loads the whole 64-bit interval into the counter at that clock edge. The counter words at base + 0xC (low) and base + 0x10 (high) are read-only, and writes to them change nothing.
- R4: A running channel decrements once per tick. In periodic mode (bit 7 clear), a tick that finds the counter at zero reloads the interval and sets the channel's status bit.
- R5: In one-shot mode (bit 7 set), a tick that finds the counter at zero sets the status bit, clears the enable bit, stops the channel and leaves the counter at zero.
- R6: Prescaler select k gives one tick per 2^k clocks. The divider restarts from zero each time enable goes from 0 to 1, so the first tick comes 2^k clocks after that write.
- R7: A control write that clears enable makes bit 0 read 0 at once. The counter takes STOP_LAT + 1 more decrements, the write edge included, and then holds.
- R8: The status register at 0x04 is write-one-to-clear, bit n for channel n. Zero bits leave their flags alone. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some channel has both its status bit and its bit in the interrupt-enable register at 0x00 set.
- R10: The two 32-bit counter words form one 64-bit counter, so a borrow from the low word decrements the high word. With an all-ones interval the channel is a free-running time base.
- R11: Channel n's registers start at 0x10 + 0x20·n. Channels are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, masked OR of the status bits |

## Verification
The bench builds the block with NUM_CH = 3 and STOP_LAT = 2. The third channel puts an address at 0x50–0x60 on the bus, which confirms that the stride is computed rather than fixed at two. A stop latency of 2 makes the extra decrements after a disable countable in a few cycles. Prescaler select 2 places the first tick after re-enable either one clock or four clocks later, depending on whether the divider restarted, so the test tells the two cases apart. A low interval word of 1 with a high word of 1 drives a borrow across the word boundary within two ticks.

// File: rtl/evt_timer_pkg.sv
// Package: shared constants and the channel control type for the event timer.
// Assumes a 32-bit register bus and byte addressing.
package evt_timer_pkg;
    localparam int DATA_W       = 32;
    localparam int PRES_W       = 3;
    localparam int OFF_IE       = 'h00;
    localparam int OFF_STS      = 'h04;
    localparam int CH_BASE      = 'h10;
    localparam int CH_STRIDE    = 'h20;
    localparam int OFF_CTRL     = 'h00;
    localparam int OFF_IVL      = 'h04;
    localparam int OFF_IVH      = 'h08;
    localparam int OFF_CNL      = 'h0C;
    localparam int OFF_CNH      = 'h10;
    localparam int CTL_EN       = 0;
    localparam int CTL_RLD      = 1;
    localparam int CTL_PRES_LSB = 4;
    localparam int CTL_OS       = 7;

    typedef struct packed {
        logic              oneshot;
        logic [PRES_W-1:0] pres;
        logic              en;
    } ctrl_t;
endpackage

// File: rtl/evt_timer_chan.sv
// Module: one timer channel with its interval, down-counter, prescaler and
// delayed-stop logic. Assumes the bus decode hands it one-cycle write strobes.
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter int STOP_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic                  ivl_we,
    input  logic                  ivh_we,
    input  logic [DATA_W-1:0]     wdata,
    output ctrl_t                 ctrl_q,
    output logic [2*DATA_W-1:0]   ival_q,
    output logic [2*DATA_W-1:0]   cnt_q,
    output logic                  running,
    output logic                  expire
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int DIV_W  = (1 << PRES_W) - 1;
    localparam int STOP_W = (STOP_LAT < 1) ? 1 : $clog2(STOP_LAT + 1);

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_mask;
    logic [STOP_W-1:0] stop_q;
    logic              tick;
    logic              at_zero;
    logic              enabling;

    // Tick and expiry decode from the divider and the counter.
    always_comb begin
        div_mask = ~({DIV_W{1'b1}} << ctrl_q.pres);
        tick     = running && ((div_q & div_mask) == div_mask);
        at_zero  = (cnt_q == '0);
        expire   = tick && at_zero;
        enabling = ctrl_we && wdata[CTL_EN] && !ctrl_q.en;
    end

    // Interval register, written one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else begin
            if (ivl_we) ival_q[DATA_W-1:0]     <= wdata;
            if (ivh_we) ival_q[CNT_W-1:DATA_W] <= wdata;
        end
    end

    // Control fields, the run flag, and the stop-latency window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            running <= 1'b0;
            stop_q  <= '0;
        end else if (ctrl_we) begin
            ctrl_q.en      <= wdata[CTL_EN];
            ctrl_q.pres    <= wdata[CTL_PRES_LSB +: PRES_W];
            ctrl_q.oneshot <= wdata[CTL_OS];
            if (wdata[CTL_EN]) begin
                running <= 1'b1;
                stop_q  <= '0;
            end else if (ctrl_q.en) begin
                stop_q  <= STOP_W'(STOP_LAT);
                if (STOP_LAT == 0) running <= 1'b0;
            end
        end else if (expire && ctrl_q.oneshot) begin
            ctrl_q.en <= 1'b0;
            running   <= 1'b0;
            stop_q    <= '0;
        end else if (stop_q != '0) begin
            stop_q <= stop_q - STOP_W'(1);
            if (stop_q == STOP_W'(1)) running <= 1'b0;
        end
    end

    // Prescale divider and the 64-bit down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            if (enabling)     div_q <= '0;
            else if (running) div_q <= div_q + DIV_W'(1);
            if (ctrl_we && wdata[CTL_RLD]) begin
                cnt_q <= ival_q;
            end else if (tick) begin
                if (at_zero) cnt_q <= ctrl_q.oneshot ? '0 : ival_q;
                else         cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/evt_timer_irq.sv
// Module: interrupt enable and sticky status registers. Merges them into
// one level interrupt. Assumes a status set wins over a clear in the same cycle.
module evt_timer_irq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_we,
    input  logic              sts_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ie_q,
    output logic [NUM_CH-1:0] sts_q,
    output logic              irq
);
    // Enable mask and write-one-to-clear status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= '0;
            sts_q <= '0;
        end else begin
            if (ie_we) ie_q <= wbits;
            sts_q <= (sts_q & ~(sts_we ? wbits : '0)) | expire;
        end
    end

    // Level interrupt from the masked status.
    always_comb irq = |(sts_q & ie_q);
endmodule

// File: rtl/evt_timer_top.sv
// Module: register decode and read mux for NUM_CH timer channels plus the
// shared interrupt registers. Assumes ADDR_W is wide enough for the last channel.
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 8,
    parameter int STOP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int off);
        return ADDR_W'(CH_BASE + CH_STRIDE * ch + off);
    endfunction

    logic [NUM_CH-1:0]            ctrl_we_v;
    logic [NUM_CH-1:0]            exp_v;
    logic [NUM_CH-1:0]            run_v;
    logic [NUM_CH-1:0]            os_v;
    logic [NUM_CH-1:0]            ie_q;
    logic [NUM_CH-1:0]            sts_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CH-1:0][CNT_W-1:0] ival_all;
    logic [DATA_W-1:0]            ctrl_rd [NUM_CH];
    logic                         ie_we;
    logic                         sts_we;

    // Strobes for the shared registers.
    always_comb begin
        ie_we  = bus_wr && (bus_addr == ADDR_W'(OFF_IE));
        sts_we = bus_wr && (bus_addr == ADDR_W'(OFF_STS));
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ctrl_t ctrl_g;
        logic  ivl_we_g;
        logic  ivh_we_g;

        // Per-channel write strobes at the channel's stride.
        always_comb begin
            ctrl_we_v[g] = bus_wr && (bus_addr == reg_addr(g, OFF_CTRL));
            ivl_we_g     = bus_wr && (bus_addr == reg_addr(g, OFF_IVL));
            ivh_we_g     = bus_wr && (bus_addr == reg_addr(g, OFF_IVH));
        end

        evt_timer_chan #(.STOP_LAT(STOP_LAT)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we_v[g]),
            .ivl_we  (ivl_we_g),
            .ivh_we  (ivh_we_g),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_g),
            .ival_q  (ival_all[g]),
            .cnt_q   (cnt_all[g]),
            .running (run_v[g]),
            .expire  (exp_v[g])
        );

        // Control readback; the reload bit always reads zero.
        always_comb begin
            ctrl_rd[g]                           = '0;
            ctrl_rd[g][CTL_EN]                   = ctrl_g.en;
            ctrl_rd[g][CTL_PRES_LSB +: PRES_W]   = ctrl_g.pres;
            ctrl_rd[g][CTL_OS]                   = ctrl_g.oneshot;
            os_v[g]                              = ctrl_g.oneshot;
        end
    end

    evt_timer_irq #(.NUM_CH(NUM_CH)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ie_we  (ie_we),
        .sts_we (sts_we),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .expire (exp_v),
        .ie_q   (ie_q),
        .sts_q  (sts_q),
        .irq    (irq)
    );

    // Combinational read mux over all registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IE))  bus_rdata = DATA_W'(ie_q);
        if (bus_addr == ADDR_W'(OFF_STS)) bus_rdata = DATA_W'(sts_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == reg_addr(i, OFF_CTRL)) bus_rdata = ctrl_rd[i];
            if (bus_addr == reg_addr(i, OFF_IVL))  bus_rdata = ival_all[i][DATA_W-1:0];
            if (bus_addr == reg_addr(i, OFF_IVH))  bus_rdata = ival_all[i][CNT_W-1:DATA_W];
            if (bus_addr == reg_addr(i, OFF_CNL))  bus_rdata = cnt_all[i][DATA_W-1:0];
            if (bus_addr == reg_addr(i, OFF_CNH))  bus_rdata = cnt_all[i][CNT_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
// Module: assertion checker for evt_timer_top, attached by bind below.
// Assumes STOP_LAT >= 1 for the stop-latency property.
module evt_timer_chk #(
    parameter int NUM_CH   = 2,
    parameter int CNT_W    = 64,
    parameter int STOP_LAT = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            expire,
    input logic [NUM_CH-1:0]            sts,
    input logic [NUM_CH-1:0]            ie,
    input logic                         irq,
    input logic [NUM_CH-1:0]            running,
    input logic [NUM_CH-1:0]            oneshot,
    input logic [NUM_CH-1:0]            ctrl_we,
    input logic                         sts_we,
    input logic                         wr_en_bit,
    input logic                         wr_rld_bit,
    input logic [NUM_CH-1:0]            clr_bits,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);
    // R9: with every enable bit clear the interrupt stays low.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R8: an expiry always leaves the status bit set.
        p_sts_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            expire[n] |=> sts[n]);
        // R8: a one-bit clear without a coincident expiry clears the flag.
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_we && clr_bits[n] && !expire[n]) |=> !sts[n]);
        // R5: one-shot expiry stops the channel with the counter at zero.
        p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[n] && oneshot[n] && !ctrl_we[n]) |=> (!running[n] && cnt_all[n] == '0));
        // R3: an idle channel's counter moves only on a reload write.
        p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[n] && !(ctrl_we[n] && wr_rld_bit)) |=> $stable(cnt_all[n]));
        if (STOP_LAT >= 1) begin : g_lat
            // R7: a disable write does not stop the channel on the next edge.
            p_stop_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_we[n] && !wr_en_bit && running[n] && !expire[n]) |=> running[n]);
        end
    end
endmodule

bind evt_timer_top evt_timer_chk #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .STOP_LAT(STOP_LAT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (exp_v),
    .sts        (sts_q),
    .ie         (ie_q),
    .irq        (irq),
    .running    (run_v),
    .oneshot    (os_v),
    .ctrl_we    (ctrl_we_v),
    .sts_we     (sts_we),
    .wr_en_bit  (bus_wdata[0]),
    .wr_rld_bit (bus_wdata[1]),
    .clr_bits   (bus_wdata[NUM_CH-1:0]),
    .cnt_all    (cnt_all)
);

// File: tb/evt_timer_top_tb_top.sv
`timescale 1ns/1ps
// Bench: a table of bus operations with expected read values, then directed
// tests for prescaling, word borrow, free-run and reset.
module evt_timer_top_tb_top;
    localparam int NUM_CH   = 3;
    localparam int ADDR_W   = 8;
    localparam int STOP_LAT = 2;
    localparam int NV       = 62;
    // Vector: op[45:44] (0 write, 1 read, 2 idle cycles, 3 irq check), req[43:40], addr[39:32], data[31:0]
    localparam logic [45:0] VEC [NV] = '{
        {2'd1, 4'd1, 8'h00, 32'h0},        // R1 ie
        {2'd1, 4'd1, 8'h04, 32'h0},        // R1 status
        {2'd1, 4'd1, 8'h10, 32'h0},        // R1 ctrl
        {2'd1, 4'd1, 8'h1C, 32'h0},        // R1 counter
        {2'd3, 4'd1, 8'h00, 32'h0},        // R1 irq low
        {2'd0, 4'd2, 8'h14, 32'd9},        // R2
        {2'd0, 4'd2, 8'h18, 32'h12345678}, // R2
        {2'd1, 4'd2, 8'h18, 32'h12345678}, // R2 high word
        {2'd0, 4'd2, 8'h18, 32'h0},        // R2
        {2'd1, 4'd2, 8'h14, 32'd9},        // R2 low word
        {2'd0, 4'd2, 8'h10, 32'h72},       // R2 reload, pres 7
        {2'd1, 4'd2, 8'h10, 32'h70},       // R2 reload reads 0
        {2'd1, 4'd3, 8'h1C, 32'd9},        // R3 loaded
        {2'd1, 4'd3, 8'h20, 32'h0},        // R3 high loaded
        {2'd0, 4'd3, 8'h1C, 32'h55},       // R3 write ignored
        {2'd1, 4'd3, 8'h1C, 32'd9},        // R3
        {2'd0, 4'd9, 8'h00, 32'h1},        // R9 enable ch0 irq
        {2'd0, 4'd4, 8'h10, 32'h01},       // R4 start periodic
        {2'd1, 4'd4, 8'h1C, 32'd9},        // R4
        {2'd2, 4'd4, 8'h00, 32'd3},        // R4
        {2'd1, 4'd4, 8'h1C, 32'd6},        // R4 counting down
        {2'd2, 4'd4, 8'h00, 32'd6},        // R4
        {2'd1, 4'd4, 8'h1C, 32'd0},        // R4 at zero
        {2'd1, 4'd4, 8'h04, 32'h0},        // R4 no expiry yet
        {2'd2, 4'd4, 8'h00, 32'd1},        // R4
        {2'd1, 4'd4, 8'h1C, 32'd9},        // R4 reloaded
        {2'd1, 4'd4, 8'h04, 32'h1},        // R4 status set
        {2'd3, 4'd9, 8'h00, 32'h1},        // R9 irq high
        {2'd0, 4'd9, 8'h00, 32'h0},        // R9 mask
        {2'd3, 4'd9, 8'h00, 32'h0},        // R9 masked
        {2'd0, 4'd9, 8'h00, 32'h1},        // R9
        {2'd3, 4'd9, 8'h00, 32'h1},        // R9
        {2'd0, 4'd8, 8'h04, 32'h0},        // R8 zero write
        {2'd1, 4'd8, 8'h04, 32'h1},        // R8 flag kept
        {2'd0, 4'd8, 8'h04, 32'h1},        // R8 clear
        {2'd1, 4'd8, 8'h04, 32'h0},        // R8 cleared
        {2'd3, 4'd9, 8'h00, 32'h0},        // R9
        {2'd1, 4'd4, 8'h1C, 32'd5},        // R4 periodic continues
        {2'd0, 4'd7, 8'h10, 32'h00},       // R7 disable
        {2'd1, 4'd7, 8'h1C, 32'd4},        // R7 still counting
        {2'd1, 4'd7, 8'h10, 32'h0},        // R7 enable reads 0
        {2'd2, 4'd7, 8'h00, 32'd1},        // R7
        {2'd1, 4'd7, 8'h1C, 32'd3},        // R7
        {2'd2, 4'd7, 8'h00, 32'd4},        // R7
        {2'd1, 4'd7, 8'h1C, 32'd2},        // R7 held after STOP_LAT+1
        {2'd0, 4'd5, 8'h30, 32'h83},       // R5 ch1 one-shot, interval 0
        {2'd0, 4'd8, 8'h04, 32'h2},        // R8 clear on expiry cycle
        {2'd1, 4'd8, 8'h04, 32'h2},        // R8 set wins
        {2'd1, 4'd5, 8'h30, 32'h80},       // R5 enable cleared
        {2'd3, 4'd9, 8'h00, 32'h0},        // R9 ch1 masked
        {2'd0, 4'd11, 8'h34, 32'd3},       // R11 ch1 interval
        {2'd0, 4'd8, 8'h04, 32'h2},        // R8
        {2'd1, 4'd8, 8'h04, 32'h0},        // R8
        {2'd0, 4'd5, 8'h30, 32'h83},       // R5 one-shot from 3
        {2'd2, 4'd5, 8'h00, 32'd3},        // R5
        {2'd1, 4'd5, 8'h30, 32'h81},       // R5 still enabled
        {2'd1, 4'd5, 8'h04, 32'h0},        // R5
        {2'd2, 4'd5, 8'h00, 32'd1},        // R5 expiry
        {2'd1, 4'd5, 8'h04, 32'h2},        // R5 status
        {2'd1, 4'd5, 8'h30, 32'h80},       // R5 stopped
        {2'd2, 4'd5, 8'h00, 32'd3},        // R5
        {2'd1, 4'd5, 8'h3C, 32'h0}         // R5 held at zero
    };

    logic              clk;
    logic              rst_n;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic              irq;
    int                n_chk;
    int                n_bad;

    evt_timer_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STOP_LAT(STOP_LAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata, e);
        end
    endtask

    task automatic irq_chk(input string req, input logic e);
        #1;
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq: got %b expected %b", req, irq, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        n_chk = 0; n_bad = 0;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][43:40]);
            case (VEC[i][45:44])
                2'd0: wr(VEC[i][39:32], VEC[i][31:0]);
                2'd1: rd_chk(tag, VEC[i][39:32], VEC[i][31:0]);
                2'd2: idle(int'(VEC[i][31:0]));
                default: irq_chk(tag, VEC[i][0]);
            endcase
        end

        // R6: prescale by 4 on channel 2, divider restart on re-enable
        wr(8'h54, 32'd100);
        wr(8'h50, 32'h23);
        idle(3); rd_chk("R6", 8'h5C, 32'd100);
        idle(1); rd_chk("R6", 8'h5C, 32'd99);
        idle(4); rd_chk("R6", 8'h5C, 32'd98);
        wr(8'h50, 32'h20);
        idle(3); rd_chk("R7", 8'h5C, 32'd98);
        wr(8'h50, 32'h21);
        idle(3); rd_chk("R6", 8'h5C, 32'd98);
        idle(1); rd_chk("R6", 8'h5C, 32'd97);
        // R11: channel registers independent at the 0x20 stride
        rd_chk("R11", 8'h54, 32'd100);
        rd_chk("R11", 8'h14, 32'd9);
        rd_chk("R11", 8'h1C, 32'd2);

        // R10: borrow from the low word into the high word
        wr(8'h34, 32'd1);
        wr(8'h38, 32'd1);
        wr(8'h30, 32'h03);
        rd_chk("R10", 8'h40, 32'd1);
        idle(2);
        rd_chk("R10", 8'h3C, 32'hFFFF_FFFF);
        rd_chk("R10", 8'h40, 32'h0);
        // R10: all-ones interval as a free-running time base
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h30, 32'h03);
        rd_chk("R10", 8'h3C, 32'hFFFF_FFFF);
        idle(5);
        rd_chk("R10", 8'h3C, 32'hFFFF_FFFA);
        rd_chk("R10", 8'h40, 32'hFFFF_FFFF);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd_chk("R1", 8'h00, 32'h0);
        rd_chk("R1", 8'h04, 32'h0);
        rd_chk("R1", 8'h30, 32'h0);
        rd_chk("R1", 8'h3C, 32'h0);
        rd_chk("R1", 8'h54, 32'h0);
        irq_chk("R1", 1'b0);
        idle(2);
        rd_chk("R1", 8'h5C, 32'h0);

        finish_run();
    end
endmodule